// File: doc/BRIEF.md
# Clamped Proportional-Integral Feedback Controller

This block closes a fixed-point feedback loop on one stream of 14-bit signed samples, taking one sample per clock. The error is the setpoint minus the incoming sample. The output is the sum of two terms: the error times a proportional gain, and an integrator that grows each clock by the error times an integral gain. That sum is then confined between a programmable lower limit and a programmable upper limit. Samples, setpoint and limits share one scale of 2^13 counts per volt.

The integrator is a 16-bit register counted in output units, so it covers about plus or minus four volts with one count per step. It sits on a read port at all times. A write through the configuration port loads it, which lets software place a fixed output offset. While the output is pinned against a limit, the integrator will not run further in the direction of that limit. This keeps it from winding up.

The configuration port is a single-cycle write strobe with a word address and 16 bits of data. No derivative term exists and no filter sits in front of the error. The output depends only on the proportional and integral terms.

Top module: `pi_ctrl`

## Requirements
- R1: After reset the output, the integrator, the setpoint and both gains are zero, the lower limit is -8192 and the upper limit is 8191.
- R2: A write with `cfg_we` high takes effect at the next rising clock edge. The word addresses are: integrator 0x100, setpoint 0x104, proportional gain 0x108, integral gain 0x10C, lower limit 0x124, upper limit 0x128. Setpoint and limits take data bits 13:0 as a signed value. Gains and the integrator take all 16 bits as a signed value.
- R3: The error is setpoint minus sample, held as a 15-bit signed value that never wraps. A setpoint of 8191 and a sample of -8192 give an error of +16383.
- R4: The proportional term is (error × proportional gain) arithmetically shifted right by PSHIFT (default 8, so 256 means a gain of 1). The unclamped output is this term plus the integrator.
- R5: A sample reaches `dout` two clocks after the edge that captures it. The edge in between latches only the error.
- R6: On each clock with no load and no hold, the integrator adds (error × integral gain) shifted right by ISHIFT (default 12). The result saturates to -32768..32767.
- R7: A write to the integrator address replaces its value at the next edge, and that write wins over accumulation in the same cycle.
- R8: `integ_rd` shows the current integrator value at all times.
- R9: `dout` is the upper limit when the unclamped sum is above it, otherwise the lower limit when the sum is below that, otherwise the sum itself. The output therefore saturates and never wraps.
- R10: The integrator holds its value when its increment is positive and the unclamped sum is at or above the upper limit. It also holds when its increment is negative and the sum is at or below the lower limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Word address of the write |
| cfg_wdata | input | 16 | Write data |
| din | input | 14 | Signed input sample |
| dout | output | 14 | Signed clamped controller output |
| integ_rd | output | 16 | Current integrator value |

## Verification
Configuration writes and integrator loads appear one clock after the strobed edge. A sample change appears at `dout` two clocks later, because the edge in between latches only the error. An integrator increment first appears at `integ_rd` one clock after its error has been latched. The reference model steps once on each rising edge in this same order. It compares `dout` and `integ_rd` on every falling edge. The directed checks wait exactly the one or two edges each result needs, so the latency test also confirms that the output has not yet moved after the first edge.

// File: rtl/pi_pkg.sv
`timescale 1ns/1ps
package pi_pkg;
  localparam int DW = 14;        // sample, setpoint, limit width
  localparam int EW = DW + 1;    // error width, one guard bit
  localparam int GW = 16;        // gain width
  localparam int IW = 16;        // integrator width
  localparam int CW = 16;        // config data width
  localparam int AW = 12;        // config address width
  localparam int XW = 32;        // wide arithmetic width

  typedef logic signed [DW-1:0] smp_t;
  typedef logic signed [EW-1:0] err_t;
  typedef logic signed [GW-1:0] gain_t;
  typedef logic signed [IW-1:0] integ_t;
  typedef logic signed [XW-1:0] wide_t;

  localparam smp_t SMP_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam smp_t SMP_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam wide_t INT_MIN = -(wide_t'(1) <<< (IW-1));
  localparam wide_t INT_MAX = (wide_t'(1) <<< (IW-1)) - wide_t'(1);

  localparam logic [AW-1:0] ADR_INTEG = 12'h100;
  localparam logic [AW-1:0] ADR_SETPT = 12'h104;
  localparam logic [AW-1:0] ADR_KPROP = 12'h108;
  localparam logic [AW-1:0] ADR_KINT  = 12'h10C;
  localparam logic [AW-1:0] ADR_LOLIM = 12'h124;
  localparam logic [AW-1:0] ADR_HILIM = 12'h128;

  typedef struct packed {
    smp_t  setpt;
    gain_t kprop;
    gain_t kint;
    smp_t  lolim;
    smp_t  hilim;
  } pi_cfg_t;

  // error times gain, then arithmetic shift by the binary-point position
  function automatic wide_t gain_scale(err_t e, gain_t g, int sh);
    wide_t prod;
    prod = wide_t'(e) * wide_t'(g);
    return prod >>> sh;
  endfunction

  function automatic integ_t integ_sat(wide_t v);
    if (v > INT_MAX) return integ_t'(INT_MAX);
    if (v < INT_MIN) return integ_t'(INT_MIN);
    return integ_t'(v);
  endfunction

  // upper limit is tested first
  function automatic smp_t out_clamp(wide_t s, smp_t lo, smp_t hi);
    if (s > wide_t'(hi)) return hi;
    if (s < wide_t'(lo)) return lo;
    return smp_t'(s);
  endfunction
endpackage

// File: rtl/pi_cfg_regs.sv
`timescale 1ns/1ps
module pi_cfg_regs import pi_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output pi_cfg_t       cfg,
  output logic          ld_integ,
  output integ_t        ld_val
);
  assign ld_integ = we && (addr == ADR_INTEG);
  assign ld_val   = integ_t'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.setpt <= '0;
      cfg.kprop <= '0;
      cfg.kint  <= '0;
      cfg.lolim <= SMP_MIN;
      cfg.hilim <= SMP_MAX;
    end else if (we) begin
      case (addr)
        ADR_SETPT: cfg.setpt <= smp_t'(wdata[DW-1:0]);
        ADR_KPROP: cfg.kprop <= gain_t'(wdata);
        ADR_KINT:  cfg.kint  <= gain_t'(wdata);
        ADR_LOLIM: cfg.lolim <= smp_t'(wdata[DW-1:0]);
        ADR_HILIM: cfg.hilim <= smp_t'(wdata[DW-1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pi_err_stage.sv
`timescale 1ns/1ps
module pi_err_stage import pi_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  smp_t din,
  input  smp_t setpt,
  output err_t err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_t'(setpt) - err_t'(din);
  end
endmodule

// File: rtl/pi_integrator.sv
`timescale 1ns/1ps
module pi_integrator import pi_pkg::*; #(
  parameter int ISHIFT = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  err_t   err_q,
  input  gain_t  kint,
  input  wide_t  sum,
  input  smp_t   lolim,
  input  smp_t   hilim,
  input  logic   ld_integ,
  input  integ_t ld_val,
  output integ_t integ_q,
  output wide_t  inc
);
  logic hold_up, hold_dn;

  assign inc     = gain_scale(err_q, kint, ISHIFT);
  assign hold_up = (inc > 0) && (sum >= wide_t'(hilim));
  assign hold_dn = (inc < 0) && (sum <= wide_t'(lolim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                integ_q <= '0;
    else if (ld_integ)         integ_q <= ld_val;
    else if (!hold_up && !hold_dn)
      integ_q <= integ_sat(wide_t'(integ_q) + inc);
  end
endmodule

// File: rtl/pi_out_stage.sv
`timescale 1ns/1ps
module pi_out_stage import pi_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  wide_t sum,
  input  smp_t  lolim,
  input  smp_t  hilim,
  output smp_t  dout_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= out_clamp(sum, lolim, hilim);
  end
endmodule

// File: rtl/pi_ctrl.sv
`timescale 1ns/1ps
module pi_ctrl import pi_pkg::*; #(
  parameter int PSHIFT = 8,
  parameter int ISHIFT = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout,
  output logic signed [IW-1:0] integ_rd
);
  pi_cfg_t cfg;
  logic    ld_integ;
  integ_t  ld_val;
  err_t    err_q;
  integ_t  integ_q;
  wide_t   inc;
  wide_t   p_term;
  wide_t   sum;
  smp_t    dout_q;

  pi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg(cfg), .ld_integ(ld_integ), .ld_val(ld_val)
  );

  pi_err_stage u_err (
    .clk(clk), .rst_n(rst_n), .din(din), .setpt(cfg.setpt), .err_q(err_q)
  );

  assign p_term = gain_scale(err_q, cfg.kprop, PSHIFT);
  assign sum    = p_term + wide_t'(integ_q);

  pi_integrator #(.ISHIFT(ISHIFT)) u_int (
    .clk(clk), .rst_n(rst_n), .err_q(err_q), .kint(cfg.kint), .sum(sum),
    .lolim(cfg.lolim), .hilim(cfg.hilim), .ld_integ(ld_integ), .ld_val(ld_val),
    .integ_q(integ_q), .inc(inc)
  );

  pi_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .sum(sum), .lolim(cfg.lolim), .hilim(cfg.hilim),
    .dout_q(dout_q)
  );

  assign dout     = dout_q;
  assign integ_rd = integ_q;
endmodule

// File: rtl/pi_ctrl_chk.sv
`timescale 1ns/1ps
module pi_ctrl_chk import pi_pkg::*; (
  input logic   clk,
  input logic   rst_n,
  input smp_t   din,
  input smp_t   dout,
  input smp_t   setpt,
  input smp_t   lolim,
  input smp_t   hilim,
  input err_t   err_q,
  input integ_t integ_q,
  input logic   ld_integ,
  input integ_t ld_val,
  input wide_t  inc,
  input wide_t  sum
);
  err_t  sp_x, din_x;
  wide_t lo_w, hi_w;
  assign sp_x  = err_t'(setpt);
  assign din_x = err_t'(din);
  assign lo_w  = wide_t'(lolim);
  assign hi_w  = wide_t'(hilim);

  // R3: latched error equals setpoint minus sample with no wrap
  p_err_nowrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_q == $past(sp_x) - $past(din_x)));

  // R4: an in-range sum passes straight to the output
  p_out_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sum >= lo_w && sum <= hi_w) |=> (wide_t'(dout) == $past(sum)));

  // R7: an integrator load wins over accumulation
  p_integ_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_integ |=> (integ_q == $past(ld_val)));

  // R9: output stays inside steady, ordered limits
  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lolim <= hilim && $stable(lolim) && $stable(hilim)) |->
      (dout >= lolim && dout <= hilim));

  // R10: no further accumulation toward a limit already reached
  p_windup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_integ && ((inc > 0 && sum >= hi_w) || (inc < 0 && sum <= lo_w)))
      |=> $stable(integ_q));
endmodule

bind pi_ctrl pi_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .setpt(cfg.setpt),
  .lolim(cfg.lolim), .hilim(cfg.hilim), .err_q(err_q), .integ_q(integ_q),
  .ld_integ(ld_integ), .ld_val(ld_val), .inc(inc), .sum(sum)
);

// File: tb/test_pi_ctrl.sv
`timescale 1ns/1ps
module test_pi_ctrl;
  localparam int PSH = 8;
  localparam int ISH = 12;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_we;
  logic [11:0]        cfg_addr;
  logic [15:0]        cfg_wdata;
  logic signed [13:0] din;
  logic signed [13:0] dout;
  logic signed [15:0] integ_rd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit armed = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pi_ctrl #(.PSHIFT(PSH), .ISHIFT(ISH)) i_pi_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .din(din), .dout(dout), .integ_rd(integ_rd)
  );

  // behavioural reference, stepped on each rising edge
  longint m_sp = 0, m_kp = 0, m_ki = 0, m_lo = -8192, m_hi = 8191;
  longint m_err = 0, m_int = 0, m_out = 0;

  always @(posedge clk) begin
    longint p, s, i, n_int, n_out;
    if (!rst_n) begin
      m_sp = 0; m_kp = 0; m_ki = 0; m_lo = -8192; m_hi = 8191;
      m_err = 0; m_int = 0; m_out = 0;
    end else begin
      p = (m_err * m_kp) >>> PSH;
      s = p + m_int;
      i = (m_err * m_ki) >>> ISH;
      if (s > m_hi)      n_out = m_hi;
      else if (s < m_lo) n_out = m_lo;
      else               n_out = s;
      if (cfg_we && cfg_addr == 12'h100) n_int = longint'($signed(cfg_wdata));
      else if ((i > 0 && s >= m_hi) || (i < 0 && s <= m_lo)) n_int = m_int;
      else begin
        n_int = m_int + i;
        if (n_int > 32767) n_int = 32767;
        if (n_int < -32768) n_int = -32768;
      end
      m_err = m_sp - longint'(din);
      if (cfg_we) begin
        case (cfg_addr)
          12'h104: m_sp = longint'($signed(cfg_wdata[13:0]));
          12'h108: m_kp = longint'($signed(cfg_wdata));
          12'h10C: m_ki = longint'($signed(cfg_wdata));
          12'h124: m_lo = longint'($signed(cfg_wdata[13:0]));
          12'h128: m_hi = longint'($signed(cfg_wdata[13:0]));
          default: ;
        endcase
      end
      m_int = n_int;
      m_out = n_out;
    end
    armed = 1'b1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      check("R4 model dout", longint'(dout), m_out);
      check("R8 model integ_rd", longint'(integ_rd), m_int);
    end
  end

  task automatic wreg(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset dout", dout, 0);
    check("R1 reset integ", integ_rd, 0);

    // R2, R5: gain write, then a step two edges to the output
    wreg(12'h108, 16'd256);
    din = 14'sd100;
    @(negedge clk);
    check("R5 dout unchanged after one edge", dout, 0);
    @(negedge clk);
    check("R5 dout after two edges", dout, -100);

    // R9: upper then lower limit
    wreg(12'h128, 16'd1000);
    din = -14'sd5000;
    repeat (2) @(negedge clk);
    check("R9 clamp to upper limit", dout, 1000);
    wreg(12'h124, 16'hFE0C);          // -500
    din = 14'sd3000;
    repeat (2) @(negedge clk);
    check("R9 clamp to lower limit", dout, -500);

    // R3: full-scale error does not wrap
    wreg(12'h124, 16'h2000);          // -8192 in 14 bits
    wreg(12'h128, 16'h1FFF);
    wreg(12'h104, 16'h1FFF);
    din = -14'sd8192;
    repeat (2) @(negedge clk);
    check("R3 positive full-scale error", dout, 8191);
    wreg(12'h108, 16'hFF00);          // gain -1.0
    repeat (2) @(negedge clk);
    check("R3 negative full-scale product", dout, -8192);

    // R7, R6: load wins over accumulation, then accumulation
    wreg(12'h108, 16'd0);
    wreg(12'h104, 16'd0);
    din = -14'sd50;
    wreg(12'h10C, 16'd4096);
    repeat (2) @(negedge clk);
    wreg(12'h100, 16'd1234);
    check("R7 load overrides accumulation", integ_rd, 1234);
    @(negedge clk);
    check("R6 accumulate one step", integ_rd, 1284);

    // R10: hold at upper limit, release on reversal, hold at lower limit
    wreg(12'h128, 16'd300);
    wreg(12'h100, 16'd0);
    repeat (20) @(negedge clk);
    check("R10 hold at upper limit", integ_rd, 300);
    check("R9 output at upper limit", dout, 300);
    din = 14'sd50;
    repeat (2) @(negedge clk);
    check("R10 release on reversal", integ_rd, 250);
    wreg(12'h124, 16'hFF9C);          // -100
    repeat (20) @(negedge clk);
    check("R10 hold at lower limit", integ_rd, -100);
    check("R9 output at lower limit", dout, -100);

    // R6: integrator saturation, R9: output held at upper limit
    wreg(12'h124, 16'h2000);
    wreg(12'h128, 16'h1FFF);
    wreg(12'h104, 16'h1FFF);
    din = -14'sd8192;
    wreg(12'h10C, 16'h7FFF);
    wreg(12'h100, 16'd8000);
    check("R7 load value", integ_rd, 8000);
    @(negedge clk);
    check("R6 integrator saturates", integ_rd, 32767);
    repeat (2) @(negedge clk);
    check("R9 output saturates", dout, 8191);
    check("R8 readback stays saturated", integ_rd, 32767);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule